// File: doc/BRIEF.md
# Block-Indexed Branch Target Buffer

This block predicts, in the fetch stage, whether the 16-byte fetch block being fetched contains a taken branch, where in the block that branch sits, and where it goes. The fetch address selects one 4-way set. One tag is shared by all ways of a set, so the set describes exactly one aligned block. Each way describes one branch of that block by its 4-bit byte position, a 2-bit direction counter, a speculative flag and a target. A lookup ignores branches that lie before the entry byte of the fetch, so a fetch that lands in the middle of a block does not redirect on a branch it has already passed. Among the rest, the branch with the lowest byte position whose counter says taken wins.

Two write-side ports maintain the table. The update port allocates a missing branch or refreshes and trains an existing one. It is driven with the commit flag low from decode, which makes an entry speculative, and with the commit flag high at retirement, which confirms the entry. The invalidate port removes an entry that turned out not to belong to a branch instruction. When all four ways are in use, the victim is chosen by a tree pseudo-LRU. A lookup result is registered and appears one cycle after the request. It reflects any update to the same set made in the same cycle.

Top module: `btb_block_pred`

## Requirements
- R1: After reset, every entry is invalid and `pred_taken` is 0 for any lookup.
- R2: A lookup issued with `lk_en` high at a clock edge is reported on `pred_*` after that edge. After an edge with `lk_en` low, `pred_taken` is 0.
- R3: The set is `addr[7:4]` and the block tag is `addr[31:8]` (default sizes). A block whose tag differs from the set's stored tag gets no prediction.
- R4: The prediction comes from the valid way with counter bit 1 set and byte position at least `lk_addr[3:0]` (equal counts) that has the smallest byte position. `pred_off` carries that position and `pred_target` carries its target.
- R5: Each update that hits an entry raises its 2-bit counter when `up_taken` is 1 and lowers it when `up_taken` is 0, saturating at 3 and at 0. The entry predicts taken when the counter is 2 or 3.
- R6: An update that misses allocates the entry with counter value 1, so the next lookup does not predict it taken.
- R7: A newly allocated entry is speculative when `up_commit` is 0. An update with `up_commit` 1 clears the flag, and one with `up_commit` 0 leaves it. `pred_spec` reports the flag of the predicted entry.
- R8: An allocation for a block whose tag differs from the set's tag retags the set and drops every branch held for the previous block.
- R9: Allocation takes the lowest-numbered free way. With no free way, it takes the way named by a 3-bit tree: bit0 selects the pair (0 for ways 0-1, 1 for ways 2-3), and bit1 and bit2 select within each pair. The tree is reset to 0. A touch of a way points the tree away from it. Updates touch, and lookups that predict taken touch.
- R10: An invalidate whose block and byte position match a valid way clears that way, and later lookups skip it.
- R11: When an update and an invalidate address the same set in the same cycle, the invalidate is dropped.
- R12: A lookup in the same cycle as an update to the same set sees the set as it is after that update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lk_en | input | 1 | Lookup request |
| lk_addr | input | ADDR_W | Fetch address: block and entry byte |
| up_en | input | 1 | Update request |
| up_addr | input | ADDR_W | Branch address being updated |
| up_target | input | ADDR_W | Branch target to store |
| up_taken | input | 1 | Observed or assumed direction used for training |
| up_commit | input | 1 | 1 at retirement (clears speculative flag), 0 from decode |
| inv_en | input | 1 | Invalidate request |
| inv_addr | input | ADDR_W | Block and byte position of the entry to drop |
| pred_taken | output | 1 | Taken branch predicted in the looked-up block |
| pred_off | output | 4 | Byte position of the predicted branch |
| pred_target | output | ADDR_W | Target of the predicted branch |
| pred_spec | output | 1 | Predicted entry is still speculative |

## Verification
Lookups into a block holding branches at positions 3, 9 and 12, stored in a way order different from position order, are made from entry bytes 0, 4, 9 and 13. These lookups tell a true first-at-or-after selection apart from a way-order pick, and they show whether the comparison includes equality. A full set, touched in a known order and then touched by a lookup, is given one more allocation. The branch that survives distinguishes tree replacement from plain round robin or from ignoring lookup touches. Further patterns exercise counter saturation, a foreign block in the same set, and an update that collides in the same cycle with an invalidate or with a lookup.

// File: rtl/btb_pkg.sv
package btb_pkg;
  localparam int unsigned OFF_W  = 4;
  localparam int unsigned WAYS   = 4;
  localparam int unsigned WAY_W  = $clog2(WAYS);
  localparam int unsigned PLRU_W = WAYS - 1;
  localparam logic [1:0]  CTR_BLANK = 2'b01;

  typedef struct packed {
    logic             valid;
    logic             spec;
    logic [OFF_W-1:0] off;
    logic [1:0]       ctr;
  } btb_way_t;

  typedef btb_way_t [WAYS-1:0] btb_row_t;

  // tree bit0 picks the pair, bit1/bit2 pick inside pair 0-1 / 2-3
  function automatic logic [WAY_W-1:0] plru_victim(input logic [PLRU_W-1:0] b);
    return b[0] ? {1'b1, b[2]} : {1'b0, b[1]};
  endfunction
endpackage

// File: rtl/btb_plru_touch.sv
module btb_plru_touch
  import btb_pkg::*;
(
  input  logic [PLRU_W-1:0] bits_q,
  input  logic              touch_en,
  input  logic [WAY_W-1:0]  touch_way,
  output logic [PLRU_W-1:0] bits_d
);
  always_comb begin
    bits_d = bits_q;
    if (touch_en) begin
      if (!touch_way[1]) begin
        bits_d[0] = 1'b1;
        bits_d[1] = ~touch_way[0];
      end else begin
        bits_d[0] = 1'b0;
        bits_d[2] = ~touch_way[0];
      end
    end
  end

  // R9: a touched way is never the next victim
  always_comb begin
    if (touch_en) begin
      a_r9_point_away: assert (plru_victim(bits_d) != touch_way);
    end
  end
endmodule

// File: rtl/btb_row_update.sv
module btb_row_update
  import btb_pkg::*;
(
  input  btb_row_t         row_q,
  input  logic             tag_hit,
  input  logic [OFF_W-1:0] up_off,
  input  logic             up_taken,
  input  logic             up_commit,
  input  logic [WAY_W-1:0] victim,
  output btb_row_t         row_d,
  output logic             hit,
  output logic [WAY_W-1:0] way
);
  logic             has_free;
  logic [WAY_W-1:0] hit_way;
  logic [WAY_W-1:0] free_way;

  always_comb begin
    hit      = 1'b0;
    hit_way  = '0;
    has_free = 1'b0;
    free_way = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (!hit && tag_hit && row_q[w].valid && row_q[w].off == up_off) begin
        hit     = 1'b1;
        hit_way = WAY_W'(w);
      end
      if (!has_free && !(tag_hit && row_q[w].valid)) begin
        has_free = 1'b1;
        free_way = WAY_W'(w);
      end
    end
    way = hit ? hit_way : (has_free ? free_way : victim);
  end

  always_comb begin
    row_d = row_q;
    if (!tag_hit) begin
      for (int w = 0; w < WAYS; w++) row_d[w].valid = 1'b0;
    end
    if (hit) begin
      if (up_taken && row_q[way].ctr != 2'b11)
        row_d[way].ctr = row_q[way].ctr + 2'd1;
      else if (!up_taken && row_q[way].ctr != 2'b00)
        row_d[way].ctr = row_q[way].ctr - 2'd1;
      if (up_commit) row_d[way].spec = 1'b0;
    end else begin
      row_d[way].valid = 1'b1;
      row_d[way].spec  = ~up_commit;
      row_d[way].off   = up_off;
      row_d[way].ctr   = CTR_BLANK;
    end
  end

  // R8: a retagged set starts filling from way 0
  always_comb begin
    if (!tag_hit) begin
      a_r8_retag_way0: assert (way == '0);
    end
  end
endmodule

// File: rtl/btb_pick.sv
module btb_pick
  import btb_pkg::*;
(
  input  btb_row_t         row,
  input  logic             tag_hit,
  input  logic [OFF_W-1:0] entry_off,
  output logic             found,
  output logic [WAY_W-1:0] way
);
  logic [WAYS-1:0]  cand;
  logic [OFF_W-1:0] best;

  always_comb begin
    found = 1'b0;
    way   = '0;
    best  = '0;
    for (int w = 0; w < WAYS; w++) begin
      cand[w] = tag_hit && row[w].valid && row[w].ctr[1] && (row[w].off >= entry_off);
      if (cand[w] && (!found || row[w].off < best)) begin
        found = 1'b1;
        way   = WAY_W'(w);
        best  = row[w].off;
      end
    end
  end

  // R4: no eligible way lies before the chosen one
  always_comb begin
    for (int w = 0; w < WAYS; w++) begin
      if (found && cand[w]) begin
        a_r4_first_taken: assert (row[w].off >= row[way].off);
      end
    end
  end
endmodule

// File: rtl/btb_block_pred.sv
module btb_block_pred
  import btb_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned SETS   = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lk_en,
  input  logic [ADDR_W-1:0] lk_addr,
  input  logic              up_en,
  input  logic [ADDR_W-1:0] up_addr,
  input  logic [ADDR_W-1:0] up_target,
  input  logic              up_taken,
  input  logic              up_commit,
  input  logic              inv_en,
  input  logic [ADDR_W-1:0] inv_addr,
  output logic              pred_taken,
  output logic [OFF_W-1:0]  pred_off,
  output logic [ADDR_W-1:0] pred_target,
  output logic              pred_spec
);
  localparam int unsigned IDX_W = (SETS > 1) ? $clog2(SETS) : 1;
  localparam int unsigned TAG_W = ADDR_W - IDX_W - OFF_W;

  typedef logic [IDX_W-1:0] idx_t;
  typedef logic [TAG_W-1:0] tag_t;

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_pipe;
  logic       rst_core_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_core_n = rst_pipe[1];

  idx_t             up_idx, lk_idx, inv_idx;
  tag_t             up_tag, lk_tag, inv_tag;
  logic [OFF_W-1:0] up_off, lk_off, inv_off;

  assign up_idx  = up_addr[OFF_W +: IDX_W];
  assign lk_idx  = lk_addr[OFF_W +: IDX_W];
  assign inv_idx = inv_addr[OFF_W +: IDX_W];
  assign up_tag  = up_addr[ADDR_W-1 -: TAG_W];
  assign lk_tag  = lk_addr[ADDR_W-1 -: TAG_W];
  assign inv_tag = inv_addr[ADDR_W-1 -: TAG_W];
  assign up_off  = up_addr[OFF_W-1:0];
  assign lk_off  = lk_addr[OFF_W-1:0];
  assign inv_off = inv_addr[OFF_W-1:0];

  btb_row_t          ent_q  [SETS];
  btb_row_t          ent_d  [SETS];
  tag_t              tag_q  [SETS];
  tag_t              tag_d  [SETS];
  logic [PLRU_W-1:0] plru_q [SETS];
  logic [PLRU_W-1:0] plru_d [SETS];
  logic [ADDR_W-1:0] tgt_q  [SETS][WAYS];

  // update path
  btb_row_t          up_row;
  logic              up_hit, up_tag_hit;
  logic [WAY_W-1:0]  up_way, up_vic;
  logic [PLRU_W-1:0] up_plru;

  assign up_tag_hit = (tag_q[up_idx] == up_tag);
  assign up_vic     = plru_victim(plru_q[up_idx]);

  btb_row_update u_upd (
    .row_q     (ent_q[up_idx]),
    .tag_hit   (up_tag_hit),
    .up_off    (up_off),
    .up_taken  (up_taken),
    .up_commit (up_commit),
    .victim    (up_vic),
    .row_d     (up_row),
    .hit       (up_hit),
    .way       (up_way)
  );

  btb_plru_touch u_up_touch (
    .bits_q    (plru_q[up_idx]),
    .touch_en  (up_en),
    .touch_way (up_way),
    .bits_d    (up_plru)
  );

  // invalidate path
  logic             inv_hit, inv_fire;
  logic [WAY_W-1:0] inv_way;
  always_comb begin
    inv_hit = 1'b0;
    inv_way = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (!inv_hit && ent_q[inv_idx][w].valid && tag_q[inv_idx] == inv_tag &&
          ent_q[inv_idx][w].off == inv_off) begin
        inv_hit = 1'b1;
        inv_way = WAY_W'(w);
      end
    end
  end
  assign inv_fire = inv_en && inv_hit && !(up_en && up_idx == inv_idx);

  always_comb begin
    ent_d = ent_q;
    tag_d = tag_q;
    if (up_en) begin
      ent_d[up_idx] = up_row;
      tag_d[up_idx] = up_tag;
    end
    if (inv_fire) ent_d[inv_idx][inv_way].valid = 1'b0;
  end

  // lookup path reads the post-update view of the table
  btb_row_t          lk_row;
  logic              lk_found, lk_touch, same_up_lk;
  logic [WAY_W-1:0]  lk_way;
  logic [PLRU_W-1:0] lk_plru;
  logic [ADDR_W-1:0] lk_tgt;

  assign lk_row     = ent_d[lk_idx];
  assign same_up_lk = up_en && (up_idx == lk_idx);

  btb_pick u_pick (
    .row       (lk_row),
    .tag_hit   (tag_d[lk_idx] == lk_tag),
    .entry_off (lk_off),
    .found     (lk_found),
    .way       (lk_way)
  );
  assign lk_touch = lk_en && lk_found;

  btb_plru_touch u_lk_touch (
    .bits_q    (plru_q[lk_idx]),
    .touch_en  (lk_touch),
    .touch_way (lk_way),
    .bits_d    (lk_plru)
  );

  assign lk_tgt = (same_up_lk && up_way == lk_way) ? up_target : tgt_q[lk_idx][lk_way];

  always_comb begin
    plru_d = plru_q;
    if (up_en) plru_d[up_idx] = up_plru;
    if (lk_touch && !same_up_lk) plru_d[lk_idx] = lk_plru;
  end

  // state registers
  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      for (int s = 0; s < SETS; s++) begin
        ent_q[s]  <= '0;
        tag_q[s]  <= '0;
        plru_q[s] <= '0;
      end
    end else begin
      ent_q  <= ent_d;
      tag_q  <= tag_d;
      plru_q <= plru_d;
    end
  end

  always_ff @(posedge clk) begin
    if (up_en) tgt_q[up_idx][up_way] <= up_target;
  end

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      pred_taken  <= 1'b0;
      pred_off    <= '0;
      pred_target <= '0;
      pred_spec   <= 1'b0;
    end else begin
      pred_taken <= lk_touch;
      if (lk_touch) begin
        pred_off    <= lk_row[lk_way].off;
        pred_target <= lk_tgt;
        pred_spec   <= lk_row[lk_way].spec;
      end
    end
  end

  // R2: no request, no prediction on the next cycle
  a_r2_idle_quiet: assert property (@(posedge clk) disable iff (!rst_core_n)
    !lk_en |=> !pred_taken);

  // R4: never predict a branch before the entry byte
  a_r4_not_before_entry: assert property (@(posedge clk) disable iff (!rst_core_n)
    lk_en |=> (!pred_taken || pred_off >= $past(lk_off)));

  // R6: an allocated entry starts weakly not taken
  a_r6_blank_counter: assert property (@(posedge clk) disable iff (!rst_core_n)
    (up_en && !up_hit) |=> (ent_q[$past(up_idx)][$past(up_way)].valid &&
                            ent_q[$past(up_idx)][$past(up_way)].ctr == CTR_BLANK));

  // R7: a committing update leaves the entry non-speculative
  a_r7_commit_clears: assert property (@(posedge clk) disable iff (!rst_core_n)
    (up_en && up_commit) |=> !ent_q[$past(up_idx)][$past(up_way)].spec);

  // R10: an accepted invalidate removes the way
  a_r10_dropped: assert property (@(posedge clk) disable iff (!rst_core_n)
    inv_fire |=> !ent_q[$past(inv_idx)][$past(inv_way)].valid);
endmodule

// File: tb/btb_block_pred_test.sv
`timescale 1ns/1ps
module btb_block_pred_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        lk_en, up_en, up_taken, up_commit, inv_en;
  logic [31:0] lk_addr, up_addr, up_target, inv_addr;
  logic        pred_taken, pred_spec;
  logic [3:0]  pred_off;
  logic [31:0] pred_target;
  int          n_chk = 0;
  int          n_fail = 0;

  always #2.5 clk = ~clk;

  btb_block_pred uut (
    .clk(clk), .rst_n(rst_n),
    .lk_en(lk_en), .lk_addr(lk_addr),
    .up_en(up_en), .up_addr(up_addr), .up_target(up_target),
    .up_taken(up_taken), .up_commit(up_commit),
    .inv_en(inv_en), .inv_addr(inv_addr),
    .pred_taken(pred_taken), .pred_off(pred_off),
    .pred_target(pred_target), .pred_spec(pred_spec)
  );

  task automatic chk(input string req, input logic et, input logic [3:0] eo,
                     input logic [31:0] eg, input logic es);
    n_chk++;
    if (pred_taken !== et || (et && (pred_off !== eo || pred_target !== eg || pred_spec !== es))) begin
      n_fail++;
      $display("FAIL %s: got taken=%0b off=%0d tgt=%h spec=%0b, expected taken=%0b off=%0d tgt=%h spec=%0b",
               req, pred_taken, pred_off, pred_target, pred_spec, et, eo, eg, es);
    end
  endtask

  task automatic upd(input logic [31:0] a, input logic [31:0] t, input logic tk, input logic cm);
    @(negedge clk);
    up_en = 1'b1; up_addr = a; up_target = t; up_taken = tk; up_commit = cm;
    @(negedge clk);
    up_en = 1'b0;
  endtask

  task automatic look(input logic [31:0] a, input string req, input logic et,
                      input logic [3:0] eo, input logic [31:0] eg, input logic es);
    @(negedge clk);
    lk_en = 1'b1; lk_addr = a;
    @(negedge clk);
    lk_en = 1'b0;
    chk(req, et, eo, eg, es);
  endtask

  task automatic t_reset;
    look(32'h0000_1230, "R1 empty after reset", 1'b0, 4'd0, 32'h0, 1'b0);
  endtask

  task automatic t_alloc_spec;
    upd(32'h0000_0915, 32'hAAAA_0000, 1'b1, 1'b0);
    look(32'h0000_0910, "R6 blank entry not taken", 1'b0, 4'd0, 32'h0, 1'b0);
    upd(32'h0000_0915, 32'hAAAA_0040, 1'b1, 1'b0);
    look(32'h0000_0910, "R7 spec kept on decode update", 1'b1, 4'd5, 32'hAAAA_0040, 1'b1);
    upd(32'h0000_0915, 32'hAAAA_0040, 1'b1, 1'b1);
    look(32'h0000_0910, "R7 commit clears spec", 1'b1, 4'd5, 32'hAAAA_0040, 1'b0);
    upd(32'h0000_0915, 32'hAAAA_0040, 1'b1, 1'b1);
    upd(32'h0000_0915, 32'hAAAA_0040, 1'b0, 1'b1);
    look(32'h0000_0910, "R5 saturated then one step down", 1'b1, 4'd5, 32'hAAAA_0040, 1'b0);
    upd(32'h0000_0915, 32'hAAAA_0040, 1'b0, 1'b1);
    look(32'h0000_0910, "R5 trained to not taken", 1'b0, 4'd0, 32'h0, 1'b0);
  endtask

  task automatic t_first_taken;
    logic [3:0] offs [3] = '{4'd12, 4'd3, 4'd9};
    foreach (offs[i]) begin
      upd(32'h0000_1230 + 32'(offs[i]), 32'h100 + 32'(offs[i]), 1'b1, 1'b0);
      upd(32'h0000_1230 + 32'(offs[i]), 32'h100 + 32'(offs[i]), 1'b1, 1'b1);
    end
    look(32'h0000_1230, "R4 lowest from byte 0", 1'b1, 4'd3, 32'h103, 1'b0);
    look(32'h0000_1234, "R4 skip earlier branch", 1'b1, 4'd9, 32'h109, 1'b0);
    look(32'h0000_1239, "R4 equal offset counts", 1'b1, 4'd9, 32'h109, 1'b0);
    look(32'h0000_123D, "R4 nothing after entry", 1'b0, 4'd0, 32'h0, 1'b0);
    upd(32'h0000_1239, 32'h109, 1'b0, 1'b1);
    look(32'h0000_1234, "R5 not-taken way skipped", 1'b1, 4'd12, 32'h10C, 1'b0);
    look(32'h0000_4530, "R3 foreign block same set", 1'b0, 4'd0, 32'h0, 1'b0);
  endtask

  task automatic t_retag;
    upd(32'h0000_4536, 32'h206, 1'b1, 1'b0);
    look(32'h0000_1230, "R8 old block dropped", 1'b0, 4'd0, 32'h0, 1'b0);
    upd(32'h0000_4536, 32'h206, 1'b1, 1'b1);
    look(32'h0000_4530, "R8 new block predicts", 1'b1, 4'd6, 32'h206, 1'b0);
  endtask

  task automatic t_replace;
    for (int o = 0; o < 4; o++) upd(32'h0000_7750 + 32'(o), 32'h300 + 32'(o), 1'b1, 1'b0);
    for (int o = 0; o < 4; o++) upd(32'h0000_7750 + 32'(o), 32'h300 + 32'(o), 1'b1, 1'b1);
    look(32'h0000_7750, "R9 full set lookup", 1'b1, 4'd0, 32'h300, 1'b0);
    upd(32'h0000_7757, 32'h307, 1'b1, 1'b0);
    look(32'h0000_7752, "R9 tree victim was way 2", 1'b1, 4'd3, 32'h303, 1'b0);
    look(32'h0000_7751, "R9 way 1 kept", 1'b1, 4'd1, 32'h301, 1'b0);
    look(32'h0000_7750, "R9 touched way 0 kept", 1'b1, 4'd0, 32'h300, 1'b0);
  endtask

  task automatic t_invalidate;
    @(negedge clk);
    inv_en = 1'b1; inv_addr = 32'h0000_7753;
    @(negedge clk);
    inv_en = 1'b0;
    look(32'h0000_7752, "R10 invalidated way skipped", 1'b0, 4'd0, 32'h0, 1'b0);
    look(32'h0000_7751, "R10 other way kept", 1'b1, 4'd1, 32'h301, 1'b0);
  endtask

  task automatic t_collide;
    @(negedge clk);
    up_en = 1'b1; up_addr = 32'h0000_7751; up_target = 32'h301; up_taken = 1'b1; up_commit = 1'b1;
    inv_en = 1'b1; inv_addr = 32'h0000_7750;
    @(negedge clk);
    up_en = 1'b0; inv_en = 1'b0;
    look(32'h0000_7750, "R11 invalidate dropped", 1'b1, 4'd0, 32'h300, 1'b0);
  endtask

  task automatic t_forward;
    upd(32'h0000_8862, 32'h400, 1'b1, 1'b0);
    @(negedge clk);
    up_en = 1'b1; up_addr = 32'h0000_8862; up_target = 32'hBEEF_0000; up_taken = 1'b1; up_commit = 1'b1;
    lk_en = 1'b1; lk_addr = 32'h0000_8860;
    @(negedge clk);
    up_en = 1'b0; lk_en = 1'b0;
    chk("R12 same-cycle update seen", 1'b1, 4'd2, 32'hBEEF_0000, 1'b0);
  endtask

  task automatic t_idle;
    look(32'h0000_8860, "R2 result one cycle later", 1'b1, 4'd2, 32'hBEEF_0000, 1'b0);
    @(negedge clk);
    chk("R2 idle cycle clears", 1'b0, 4'd0, 32'h0, 1'b0);
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: got hung run, expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    lk_en = 1'b0; up_en = 1'b0; inv_en = 1'b0;
    lk_addr = '0; up_addr = '0; up_target = '0; inv_addr = '0;
    up_taken = 1'b0; up_commit = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_alloc_spec();
    t_first_taken();
    t_retag();
    t_replace();
    t_invalidate();
    t_collide();
    t_forward();
    t_idle();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule